// File: doc/BRIEF.md
# Calendar Clock with Write-Synchronization Flags

This block keeps the time of day and the calendar date. It advances by one second on every cycle in which the 1 Hz tick enable is high. Software uses single-cycle write strobes and a combinational read port to reach three words: a control word, a packed date word and a packed time word. The year field is an offset from a base year. Its width and the base year are parameters. The default is a 6-bit offset from 2010. An 8-bit offset from 1970 is the other usual setting.

A write does not change the counters at once. The write value is parked, and a busy flag for that word rises in the control word. The parked value replaces the counters at the next tick. That tick does no counting of its own, and the flag then drops. Software supplies the leap-year flag along with the date. When the year rolls over, the block computes the new flag itself. A time and date can change between two reads, so software reads twice and compares the results to get a consistent sample.

Top module: `tod_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 and the date reads day 1, month 1, year offset 0, leap flag 0. Both busy flags read 0.
- R2: The time word is read at addr 2. It holds seconds in bits [5:0], minutes in [13:8] and hours in [20:16]. A time write takes exactly those bits, and every other bit reads 0.
- R3: The date word is read at addr 1. It holds day in [4:0], month (1 to 12) in [11:8], the year offset in [16 +: YEAR_W] and the leap flag at bit 16+YEAR_W. A date write takes exactly those bits, and every other bit reads 0.
- R4: A time write sets control bit 8 (addr 0) from the next cycle on. The bit stays set until a tick arrives, and it clears after that tick unless another time write occurs in the same cycle as the tick.
- R5: A date write sets control bit 7 in the same way as R4, under the same rules. All other control bits read 0.
- R6: At a tick, any pending word is loaded in place of counting, and neither word advances on that tick. Until that tick, reads return the old value. A second write before the tick replaces the parked value. A write in the same cycle as a tick waits for the following tick.
- R7: Each tick with no write pending advances the seconds. Seconds go from 59 to 0 and carry into minutes. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into the day.
- R8: On a day carry, the day returns to 1 after day 29 of month 2 when the leap flag is 1, and after day 28 of month 2 otherwise. It returns to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in every other month. Otherwise the day increments.
- R9: After month 12 the month becomes 1 and the year offset increments, wrapping to 0 past its maximum. The leap flag becomes 1 exactly when BASE_YEAR plus the new offset is divisible by 4 and either not divisible by 100 or divisible by 400.
- R10: Without a tick, the counters do not change. Writes to the control word or to addr 3 have no effect on any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter-domain clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| tick | input | 1 | One-cycle 1 Hz advance enable |
| wr_en | input | 1 | Write strobe for the word selected by addr |
| addr | input | 2 | Word select: 0 control, 1 date, 2 time, 3 unused |
| wdata | input | 32 | Write value |
| rdata | output | 32 | Value of the word selected by addr (combinational) |

## Verification
The assertions assume that tick is a clean single-cycle enable. They also assume that software writes fields within their legal ranges, so that a day carry is always followed by a day of 1 and a valid month. The random stimulus draws hours, minutes and seconds close to their wrap points. It draws months from 1 to 12 and draws each day as the last day of its month or the day before it, with stray high bits added to test the masking. Directed sequences walk through the month-length, leap-year and year-wrap cases.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef struct packed {
    logic [4:0] hr;
    logic [5:0] mn;
    logic [5:0] sc;
  } hms_t;

  localparam int HMS_W = $bits(hms_t);

  function automatic logic [4:0] month_last_day(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

  function automatic logic gregorian_leap(input int unsigned yr);
    return ((yr % 4) == 0) && (((yr % 100) != 0) || ((yr % 400) == 0));
  endfunction

  function automatic logic [31:0] pack_hms(input hms_t t);
    logic [31:0] w;
    w = '0;
    w[5:0]   = t.sc;
    w[13:8]  = t.mn;
    w[20:16] = t.hr;
    return w;
  endfunction

  function automatic hms_t unpack_hms(input logic [31:0] w);
    hms_t t;
    t.sc = w[5:0];
    t.mn = w[13:8];
    t.hr = w[20:16];
    return t;
  endfunction

endpackage

// File: rtl/tod_wr_sync.sv
module tod_wr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         busy_o,
  output logic         load_o,
  output logic [W-1:0] ldata_o
);

  logic [W-1:0] park_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      park_q <= '0;
    end else if (wr_i) begin
      busy_o <= 1'b1;
      park_q <= wdata_i;
    end else if (tick_i) begin
      busy_o <= 1'b0;
    end
  end

  assign load_o  = tick_i & busy_o;
  assign ldata_o = park_q;

  // R4 / R5 busy handshake
  a_r4_r5_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> busy_o);
  a_r4_r5_hold_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> busy_o);
  a_r4_r5_clear_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && tick_i && !wr_i) |=> !busy_o);
  a_r6_idle_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !load_o);

endmodule

// File: rtl/tod_time_ctr.sv
module tod_time_ctr
  import tod_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic load_i,
  input  hms_t ldata_i,
  output hms_t hms_o,
  output logic day_carry_o
);

  hms_t hms_q, hms_n;
  logic sc_wrap, mn_wrap, hr_wrap;

  assign sc_wrap = (hms_q.sc >= 6'd59);
  assign mn_wrap = (hms_q.mn >= 6'd59);
  assign hr_wrap = (hms_q.hr >= 5'd23);

  always_comb begin
    hms_n = hms_q;
    if (load_i) begin
      hms_n = ldata_i;
    end else if (step_i) begin
      if (sc_wrap) begin
        hms_n.sc = '0;
        if (mn_wrap) begin
          hms_n.mn = '0;
          if (hr_wrap) hms_n.hr = '0;
          else         hms_n.hr = hms_q.hr + 5'd1;
        end else begin
          hms_n.mn = hms_q.mn + 6'd1;
        end
      end else begin
        hms_n.sc = hms_q.sc + 6'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hms_q <= '0;
    else        hms_q <= hms_n;
  end

  assign hms_o       = hms_q;
  assign day_carry_o = step_i & sc_wrap & mn_wrap & hr_wrap;

  a_r10_time_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(hms_q));
  a_r7_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && hms_q.sc == 6'd59) |=> (hms_q.sc == 6'd0));
  a_r7_sec_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && hms_q.sc < 6'd59) |=> (hms_q.sc == $past(hms_q.sc) + 6'd1));

endmodule

// File: rtl/tod_date_ctr.sv
module tod_date_ctr
  import tod_pkg::*;
#(
  parameter int YEAR_W    = 6,
  parameter int BASE_YEAR = 2010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [4:0]        ld_day_i,
  input  logic [3:0]        ld_mon_i,
  input  logic [YEAR_W-1:0] ld_yr_i,
  input  logic              ld_leap_i,
  output logic [4:0]        day_o,
  output logic [3:0]        mon_o,
  output logic [YEAR_W-1:0] yr_o,
  output logic              leap_o
);

  logic [4:0]        day_q, day_n;
  logic [3:0]        mon_q, mon_n;
  logic [YEAR_W-1:0] yr_q, yr_n, yr_inc;
  logic              leap_q, leap_n;
  logic              month_end, year_end;

  assign month_end = (day_q >= month_last_day(mon_q, leap_q));
  assign year_end  = (mon_q >= 4'd12);
  assign yr_inc    = yr_q + 1'b1;

  always_comb begin
    day_n  = day_q;
    mon_n  = mon_q;
    yr_n   = yr_q;
    leap_n = leap_q;
    if (load_i) begin
      day_n  = ld_day_i;
      mon_n  = ld_mon_i;
      yr_n   = ld_yr_i;
      leap_n = ld_leap_i;
    end else if (step_i) begin
      if (month_end) begin
        day_n = 5'd1;
        if (year_end) begin
          mon_n  = 4'd1;
          yr_n   = yr_inc;
          leap_n = gregorian_leap(BASE_YEAR + int'(yr_inc));
        end else begin
          mon_n = mon_q + 4'd1;
        end
      end else begin
        day_n = day_q + 5'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      day_q  <= 5'd1;
      mon_q  <= 4'd1;
      yr_q   <= '0;
      leap_q <= 1'b0;
    end else begin
      day_q  <= day_n;
      mon_q  <= mon_n;
      yr_q   <= yr_n;
      leap_q <= leap_n;
    end
  end

  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign yr_o   = yr_q;
  assign leap_o = leap_q;

  a_r10_date_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> ($stable(day_q) && $stable(mon_q) && $stable(yr_q)));
  a_r8_month_end_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && month_end) |=> (day_q == 5'd1));
  a_r9_year_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i && month_end && year_end) |=>
      (mon_q == 4'd1 && yr_q == $past(yr_q) + 1'b1));

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
#(
  parameter int YEAR_W    = 6,
  parameter int BASE_YEAR = 2010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  localparam int          LEAP_BIT   = 16 + YEAR_W;
  localparam int          DATE_W     = 5 + 4 + YEAR_W + 1;
  localparam int          TIME_BUSY  = 8;
  localparam int          DATE_BUSY  = 7;
  localparam logic [1:0]  A_CTRL     = 2'd0;
  localparam logic [1:0]  A_DATE     = 2'd1;
  localparam logic [1:0]  A_TIME     = 2'd2;

  // Write decode
  logic wr_time, wr_date;
  assign wr_time = wr_en && (addr == A_TIME);
  assign wr_date = wr_en && (addr == A_DATE);

  // Extracted write fields
  hms_t              wtime;
  logic [DATE_W-1:0] wdate;
  logic              wdata_unused;
  assign wtime        = unpack_hms(wdata);
  assign wdate        = {wdata[LEAP_BIT], wdata[16 +: YEAR_W], wdata[11:8], wdata[4:0]};
  assign wdata_unused = ^wdata;

  // Pending-write handshakes
  logic              busy_t, busy_d, load_t, load_d;
  logic [HMS_W-1:0]  park_t;
  logic [DATE_W-1:0] park_d;

  tod_wr_sync #(.W(HMS_W)) u_sync_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .wr_i    (wr_time),
    .wdata_i (wtime),
    .busy_o  (busy_t),
    .load_o  (load_t),
    .ldata_o (park_t)
  );

  tod_wr_sync #(.W(DATE_W)) u_sync_date (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .wr_i    (wr_date),
    .wdata_i (wdate),
    .busy_o  (busy_d),
    .load_o  (load_d),
    .ldata_o (park_d)
  );

  // Counting happens only on ticks with nothing pending
  logic step_time;
  assign step_time = tick && !busy_t && !busy_d;

  hms_t hms;
  logic day_carry;

  tod_time_ctr u_time (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_time),
    .load_i      (load_t),
    .ldata_i     (hms_t'(park_t)),
    .hms_o       (hms),
    .day_carry_o (day_carry)
  );

  logic [4:0]        day;
  logic [3:0]        mon;
  logic [YEAR_W-1:0] yr;
  logic              leap;

  tod_date_ctr #(.YEAR_W(YEAR_W), .BASE_YEAR(BASE_YEAR)) u_date (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_i    (day_carry),
    .load_i    (load_d),
    .ld_day_i  (park_d[4:0]),
    .ld_mon_i  (park_d[8:5]),
    .ld_yr_i   (park_d[9 +: YEAR_W]),
    .ld_leap_i (park_d[DATE_W-1]),
    .day_o     (day),
    .mon_o     (mon),
    .yr_o      (yr),
    .leap_o    (leap)
  );

  // Read mux
  logic [31:0] rd_ctrl, rd_date;
  always_comb begin
    rd_ctrl            = '0;
    rd_ctrl[TIME_BUSY] = busy_t;
    rd_ctrl[DATE_BUSY] = busy_d;
    rd_date                 = '0;
    rd_date[4:0]            = day;
    rd_date[11:8]           = mon;
    rd_date[16 +: YEAR_W]   = yr;
    rd_date[LEAP_BIT]       = leap;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = rd_ctrl;
      A_DATE:  rdata = rd_date;
      A_TIME:  rdata = pack_hms(hms);
      default: rdata = '0;
    endcase
  end

  a_r6_date_pending_freezes_time: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy_d && !busy_t) |=> $stable(hms));
  a_r6_carry_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry |-> (tick && !busy_t && !busy_d));
  a_r6_time_pending_freezes_date: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && busy_t && !busy_d) |=> ($stable(day) && $stable(mon) && $stable(yr)));

endmodule

// File: tb/tod_calendar_tb.sv
module tod_calendar_tb;

  localparam int YW   = 6;
  localparam int BASE = 2010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  tod_calendar #(.YEAR_W(YW), .BASE_YEAR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state
  int m_sc, m_mn, m_hr, m_day, m_mon, m_yr, m_lp;
  bit p_t, p_d;
  int q_sc, q_mn, q_hr, q_day, q_mon, q_yr, q_lp;

  function automatic int b_leap(int a);
    return ((a % 4) == 0 && ((a % 100) != 0 || (a % 400) == 0)) ? 1 : 0;
  endfunction

  function automatic int b_last(int mon, int lp);
    if (mon == 2) return 28 + lp;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] mk_time(int h, int m, int s);
    return 32'((h << 16) | (m << 8) | s);
  endfunction

  function automatic logic [31:0] mk_date(int d, int mo, int y, int lp);
    return 32'((lp << (16 + YW)) | (y << 16) | (mo << 8) | d);
  endfunction

  task automatic model_reset();
    m_sc = 0; m_mn = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_lp = 0;
    p_t = 0; p_d = 0;
  endtask

  task automatic model_advance();
    m_sc++;
    if (m_sc < 60) return;
    m_sc = 0; m_mn++;
    if (m_mn < 60) return;
    m_mn = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    if (m_day < b_last(m_mon, m_lp)) begin m_day++; return; end
    m_day = 1;
    if (m_mon < 12) begin m_mon++; return; end
    m_mon = 1;
    m_yr = (m_yr + 1) % (1 << YW);
    m_lp = b_leap(BASE + m_yr);
  endtask

  task automatic model_step(bit t, bit w, logic [1:0] a, logic [31:0] d);
    if (t) begin
      if (p_t || p_d) begin
        if (p_t) begin m_sc = q_sc; m_mn = q_mn; m_hr = q_hr; end
        if (p_d) begin m_day = q_day; m_mon = q_mon; m_yr = q_yr; m_lp = q_lp; end
        p_t = 0; p_d = 0;
      end else begin
        model_advance();
      end
    end
    if (w && a == 2'd2) begin
      q_sc = int'(d[5:0]); q_mn = int'(d[13:8]); q_hr = int'(d[20:16]); p_t = 1;
    end
    if (w && a == 2'd1) begin
      q_day = int'(d[4:0]); q_mon = int'(d[11:8]);
      q_yr = int'((d >> 16) & ((32'd1 << YW) - 1)); q_lp = int'(d[16 + YW]); p_d = 1;
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic verify(string tag);
    addr = 2'd0; #1;
    check(tag, "control", rdata, 32'((int'(p_t) << 8) | (int'(p_d) << 7)));
    addr = 2'd1; #1;
    check(tag, "date", rdata, mk_date(m_day, m_mon, m_yr, m_lp));
    addr = 2'd2; #1;
    check(tag, "time", rdata, mk_time(m_hr, m_mn, m_sc));
    addr = 2'd3; #1;
    check(tag, "spare", rdata, 32'd0);
  endtask

  task automatic cycle(bit t, bit w, logic [1:0] a, logic [31:0] d, string tag);
    tick = t; wr_en = w; addr = a; wdata = d;
    model_step(t, w, a, d);
    @(posedge clk); #1;
    tick = 1'b0; wr_en = 1'b0;
    verify(tag);
    @(negedge clk);
  endtask

  // Set a date and 23:59:59, apply, then roll one day
  task automatic roll_day(int d, int mo, int y, int lp, string tag);
    cycle(0, 1, 2'd2, mk_time(23, 59, 59), tag);
    cycle(0, 1, 2'd1, mk_date(d, mo, y, lp), tag);
    cycle(1, 0, 2'd0, 32'd0, tag);
    cycle(1, 0, 2'd0, 32'd0, tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    verify("R1");

    // R10: ticks-free cycles and control / spare writes change nothing
    cycle(0, 0, 2'd0, 32'd0, "R10");
    cycle(0, 1, 2'd0, 32'hFFFF_FFFF, "R10");
    cycle(0, 1, 2'd3, 32'hFFFF_FFFF, "R10");

    // R7: plain counting, R2 masking of stray bits
    cycle(1, 0, 2'd0, 32'd0, "R7");
    cycle(0, 1, 2'd2, 32'hFFC0_C0C0 | mk_time(10, 58, 59), "R2");
    cycle(1, 0, 2'd0, 32'd0, "R6");
    cycle(1, 0, 2'd0, 32'd0, "R7");
    cycle(1, 0, 2'd0, 32'd0, "R7");

    // R4 / R6: busy holds without tick, rewrite replaces parked value
    cycle(0, 1, 2'd2, mk_time(5, 6, 7), "R4");
    cycle(0, 0, 2'd0, 32'd0, "R4");
    cycle(0, 1, 2'd2, mk_time(8, 9, 10), "R6");
    cycle(0, 0, 2'd0, 32'd0, "R6");
    cycle(1, 0, 2'd0, 32'd0, "R6");
    cycle(1, 0, 2'd0, 32'd0, "R7");

    // R5 / R3: date write with stray bits, busy bit 7
    cycle(0, 1, 2'd1, 32'hFF80_E0E0 | mk_date(3, 7, 9, 0), "R3");
    cycle(0, 0, 2'd0, 32'd0, "R5");
    cycle(1, 1, 2'd1, mk_date(4, 8, 9, 0), "R5");
    cycle(0, 0, 2'd0, 32'd0, "R5");
    cycle(1, 0, 2'd0, 32'd0, "R6");

    // R8 month lengths and leap flag
    roll_day(28, 2, 7, 0, "R8");
    roll_day(28, 2, 6, 1, "R8");
    roll_day(29, 2, 6, 1, "R8");
    roll_day(30, 4, 3, 0, "R8");
    roll_day(30, 1, 3, 0, "R8");
    roll_day(31, 1, 3, 0, "R8");
    roll_day(30, 11, 3, 0, "R8");

    // R9 year rollover, leap recompute, wrap
    roll_day(31, 12, 5, 0, "R9");
    roll_day(31, 12, (1 << YW) - 1, 0, "R9");
    roll_day(31, 12, 1, 0, "R9");

    // Random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1500; i++) begin
      bit t, w;
      logic [1:0] a;
      logic [31:0] d;
      t = (($urandom % 3) == 0);
      w = (($urandom % 4) == 0);
      a = 2'($urandom % 4);
      if (a == 2'd2) begin
        d = mk_time(20 + int'($urandom % 4), 55 + int'($urandom % 5), 55 + int'($urandom % 5));
      end else if (a == 2'd1) begin
        int mo, lp;
        mo = 1 + int'($urandom % 12);
        lp = int'($urandom % 2);
        d = mk_date(b_last(mo, lp) - int'($urandom % 2), mo,
                    int'($urandom % (1 << YW)), lp);
      end else begin
        d = $urandom;
      end
      d = d | ($urandom & 32'hFE00_0000);
      cycle(t, w, a, d, "R6");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule